// File: doc/BRIEF.md
# Serial Configuration Bitstream Source

This block behaves as a one-bit-wide read-only store that feeds a configuration host one bit per clock. The host supplies the clock, a combined reset/output-enable control whose active level is fixed by a parameter, and an active-low chip enable. While both controls permit it, each rising clock edge moves an internal bit pointer forward by one. The bit at the current pointer is presented on a data output, with a separate enable that stands in for a tri-state pin driver.

The stored image is a constant computed at elaboration from a seed parameter. It is read byte by byte, most significant bit first. Once the pointer has delivered the last bit, it stops at that bit and does not wrap. The output then stays undriven until a reset or a chip-enable release clears the pointer. A standby flag reports when the chip enable is inactive.

Top module: `sprom_serial_emu`

## Requirements
- R1: While the reset/output-enable control is at its reset level, data_oe is 0 regardless of the clock.
- R2: While ce_n is 1, data_oe is 0 whatever the reset/output-enable level, and the bit pointer is cleared, so the first bit after re-enabling is bit 0.
- R3: When ce_n is 0 and the control is not at its reset level, each rising clock edge advances the bit pointer by exactly one, and data_oe is 1 until the pointer passes its last position.
- R4: Bit address a selects stored byte a/8 and, within that byte, bit position 7-(a mod 8), so each byte leaves MSB first.
- R5: Stored byte k equals (k*37 + IMG_SEED) mod 256 for k = 0 .. DEPTH_BITS/8-1.
- R6: The last position is DEPTH_BITS-1. The enabled edge taken while at that position does not wrap the pointer. From then on data_oe stays 0 and later enabled edges change nothing until a clear.
- R7: standby equals ce_n on every cycle.
- R8: Clock edges taken while the reset level is applied hold the pointer at zero, so the first bit shown after release is bit 0.
- R9: With RST_HIGH=1 a high control level is the reset level. With RST_HIGH=0 a low level is the reset level, and the opposite level enables the output.
- R10: data_o is 0 whenever data_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock from the host |
| oe_rst_pin | input | 1 | Combined reset/output-enable control; reset level set by RST_HIGH |
| ce_n | input | 1 | Active-low chip enable; high clears the pointer and enters standby |
| data_o | output | 1 | Serial bit at the current pointer, 0 when not driven |
| data_oe | output | 1 | Driver enable for data_o; high only when the output is actively driven |
| standby | output | 1 | High while the chip enable is inactive |

## Verification
On every cycle the assertions check the following: the output is quiet under reset or standby, the pointer steps by one on enabled edges, a clear holds the pointer at zero, the pointer stays put after the final bit, and standby tracks the chip enable. Only the bench scenarios can show that the bit values follow the seeded image in MSB-first order, that a full read-out ends exactly after DEPTH_BITS bits, and that both polarity variants give the same stream. The bench exercises these through directed walks and random interleavings of reset and chip enable.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

   // Image byte generator: byte k of the stored bitstream
   function automatic logic [7:0] img_byte(input int k, input int seed);
      int v;
      v = (k * 37 + seed) & 255;
      return v[7:0];
   endfunction

   typedef struct packed {
      logic clr;      // pointer clear request (reset level or chip disabled)
      logic run;      // both enables active
      logic standby;  // chip enable inactive
   } ctl_t;

endpackage

// File: rtl/sprom_ctrl_decode.sv
module sprom_ctrl_decode
   import sprom_pkg::*;
#(
   parameter bit RST_HIGH = 1'b1
) (
   input  logic oe_rst_pin,
   input  logic ce_n,
   output ctl_t ctl
);

   logic rst_lvl;

   generate
      if (RST_HIGH) begin : g_rst_high
         assign rst_lvl = oe_rst_pin;
      end else begin : g_rst_low
         assign rst_lvl = ~oe_rst_pin;
      end
   endgenerate

   always_comb begin
      ctl.standby = ce_n;
      ctl.clr     = rst_lvl | ce_n;
      ctl.run     = ~rst_lvl & ~ce_n;
   end

endmodule

// File: rtl/sprom_addr_ctr.sv
module sprom_addr_ctr #(
   parameter int DEPTH_BITS = 256,
   localparam int AW = $clog2(DEPTH_BITS)
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          run,
   output logic [AW-1:0] addr,
   output logic          past_tc
);

   localparam logic [AW-1:0] TC = AW'(DEPTH_BITS - 1);

   always_ff @(posedge clk) begin
      if (clr) begin
         addr    <= '0;
         past_tc <= 1'b0;
      end else if (run && !past_tc) begin
         if (addr == TC) begin
            past_tc <= 1'b1;
         end else begin
            addr <= addr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sprom_bit_rom.sv
module sprom_bit_rom
   import sprom_pkg::*;
#(
   parameter int DEPTH_BITS = 256,
   parameter int IMG_SEED   = 8'h5A,
   localparam int AW     = $clog2(DEPTH_BITS),
   localparam int NBYTES = DEPTH_BITS / 8
) (
   input  logic [AW-1:0] addr,
   output logic          bit_o
);

   logic [7:0] img [NBYTES];

   generate
      for (genvar k = 0; k < NBYTES; k++) begin : g_byte
         assign img[k] = img_byte(k, IMG_SEED);
      end
   endgenerate

   logic [AW-4:0] byte_sel;
   logic [2:0]    bit_sel;

   always_comb begin
      byte_sel = addr[AW-1:3];
      bit_sel  = 3'd7 - addr[2:0];
      bit_o    = img[byte_sel][bit_sel];
   end

endmodule

// File: rtl/sprom_serial_emu.sv
module sprom_serial_emu
   import sprom_pkg::*;
#(
   parameter int DEPTH_BITS = 256,
   parameter int IMG_SEED   = 8'h5A,
   parameter bit RST_HIGH   = 1'b1,
   localparam int AW = $clog2(DEPTH_BITS)
) (
   input  logic clk,
   input  logic oe_rst_pin,
   input  logic ce_n,
   output logic data_o,
   output logic data_oe,
   output logic standby
);

   generate
      if (DEPTH_BITS < 16 || (DEPTH_BITS % 8) != 0 || (1 << AW) != DEPTH_BITS) begin : g_bad_depth
         $error("DEPTH_BITS must be a power of two, at least 16");
      end
      if (IMG_SEED < 0 || IMG_SEED > 255) begin : g_bad_seed
         $error("IMG_SEED must fit in one byte");
      end
   endgenerate

   ctl_t          ctl;
   logic [AW-1:0] addr;
   logic          past_tc;
   logic          rom_bit;

   sprom_ctrl_decode #(.RST_HIGH(RST_HIGH)) u_dec (
      .oe_rst_pin (oe_rst_pin),
      .ce_n       (ce_n),
      .ctl        (ctl)
   );

   sprom_addr_ctr #(.DEPTH_BITS(DEPTH_BITS)) u_ctr (
      .clk     (clk),
      .clr     (ctl.clr),
      .run     (ctl.run),
      .addr    (addr),
      .past_tc (past_tc)
   );

   sprom_bit_rom #(.DEPTH_BITS(DEPTH_BITS), .IMG_SEED(IMG_SEED)) u_rom (
      .addr  (addr),
      .bit_o (rom_bit)
   );

   always_comb begin
      data_oe = ctl.run & ~past_tc;
      data_o  = data_oe & rom_bit;
      standby = ctl.standby;
   end

endmodule

// File: rtl/sprom_serial_emu_chk.sv
module sprom_serial_emu_chk #(
   parameter int DEPTH_BITS = 256,
   parameter bit RST_HIGH   = 1'b1,
   localparam int AW = $clog2(DEPTH_BITS)
) (
   input logic          clk,
   input logic          oe_rst_pin,
   input logic          ce_n,
   input logic          data_o,
   input logic          data_oe,
   input logic          standby,
   input logic [AW-1:0] addr,
   input logic          past_tc
);

   localparam logic [AW-1:0] TC = AW'(DEPTH_BITS - 1);

   logic at_rst;
   logic go;
   logic armed = 1'b0;

   assign at_rst = (oe_rst_pin == RST_HIGH);
   assign go     = !at_rst && !ce_n;

   always_ff @(posedge clk) armed <= armed | at_rst | ce_n;

   a_r1_reset_hiz: assert property (@(posedge clk) disable iff (!armed)
      at_rst |-> !data_oe);

   a_r2_ce_off_hiz: assert property (@(posedge clk) disable iff (!armed)
      ce_n |-> (!data_oe && standby));

   a_r2_ce_clears: assert property (@(posedge clk) disable iff (!armed)
      ce_n |=> (addr == '0 && !past_tc));

   a_r3_single_step: assert property (@(posedge clk) disable iff (!armed)
      (go && !past_tc && addr != TC) |=> (addr == $past(addr) + 1'b1));

   a_r6_tc_no_wrap: assert property (@(posedge clk) disable iff (!armed)
      (go && addr == TC) |=> (addr == TC && past_tc));

   a_r6_done_quiet: assert property (@(posedge clk) disable iff (!armed)
      past_tc |-> !data_oe);

   a_r7_standby_tracks: assert property (@(posedge clk) disable iff (!armed)
      standby == ce_n);

   a_r8_reset_holds_zero: assert property (@(posedge clk) disable iff (!armed)
      at_rst |=> (addr == '0));

   a_r10_quiet_low: assert property (@(posedge clk) disable iff (!armed)
      !data_oe |-> !data_o);

endmodule

bind sprom_serial_emu sprom_serial_emu_chk #(
   .DEPTH_BITS (DEPTH_BITS),
   .RST_HIGH   (RST_HIGH)
) u_chk (
   .clk        (clk),
   .oe_rst_pin (oe_rst_pin),
   .ce_n       (ce_n),
   .data_o     (data_o),
   .data_oe    (data_oe),
   .standby    (standby),
   .addr       (addr),
   .past_tc    (past_tc)
);

// File: tb/sprom_serial_emu_tb_top.sv
`timescale 1ns/1ps
module sprom_serial_emu_tb_top;

   localparam int DEPTH = 256;
   localparam int SEED  = 8'h5A;
   localparam int TC    = DEPTH - 1;

   logic clk = 1'b0;
   logic pin_hi = 1'b1;
   logic pin_lo = 1'b0;
   logic ce_n = 1'b0;
   logic d_hi, oe_hi, sb_hi;
   logic d_lo, oe_lo, sb_lo;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   int  m_addr = 0;
   bit  m_past = 1'b0;
   bit  prev_rst = 1'b0;

   always #10 clk = ~clk;

   sprom_serial_emu #(.DEPTH_BITS(DEPTH), .IMG_SEED(SEED), .RST_HIGH(1'b1)) dut_i (
      .clk(clk), .oe_rst_pin(pin_hi), .ce_n(ce_n),
      .data_o(d_hi), .data_oe(oe_hi), .standby(sb_hi)
   );

   sprom_serial_emu #(.DEPTH_BITS(DEPTH), .IMG_SEED(SEED), .RST_HIGH(1'b0)) dut_lo (
      .clk(clk), .oe_rst_pin(pin_lo), .ce_n(ce_n),
      .data_o(d_lo), .data_oe(oe_lo), .standby(sb_lo)
   );

   // R5 image bytes and R4 MSB-first bit order
   function automatic bit exp_bit(input int a);
      int b;
      b = ((a / 8) * 37 + SEED) % 256;
      return b[7 - (a % 8)];
   endfunction

   task automatic check(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b (addr model %0d)", tag, act, exp, m_addr);
      end
   endtask

   task automatic cyc(input bit rst, input bit cen);
      bit exp_oe;
      bit exp_d;
      string t_oe;
      @(negedge clk);
      pin_hi = rst;
      pin_lo = !rst;
      ce_n   = cen;
      #1;
      exp_oe = !rst && !cen && !m_past;
      exp_d  = exp_oe ? exp_bit(m_addr) : 1'b0;
      if (cen)                         t_oe = "R2";
      else if (rst)                    t_oe = "R1";
      else if (m_past)                 t_oe = "R6";
      else if (prev_rst && m_addr == 0) t_oe = "R8";
      else                             t_oe = "R3";
      check(t_oe, oe_hi, exp_oe);
      check(exp_oe ? "R4/R5" : "R10", d_hi, exp_d);
      check("R7", sb_hi, cen);
      check("R9 oe", oe_lo, exp_oe);
      check("R9 data", d_lo, exp_d);
      check("R9 standby", sb_lo, cen);
      prev_rst = rst;
      @(posedge clk);
      if (rst || cen) begin
         m_addr = 0;
         m_past = 1'b0;
      end else if (!m_past) begin
         if (m_addr == TC) m_past = 1'b1;
         else m_addr++;
      end
   endtask

   initial begin
      void'($urandom(32'h1F2E3D4C));
      // R1 / R8: reset applied with clocks running
      repeat (3) cyc(1'b1, 1'b0);
      // R3 R4 R5 R6: full walk plus extra edges past the last bit
      repeat (DEPTH + 5) cyc(1'b0, 1'b0);
      // R2 R7: standby clears the pointer even while stream was finished
      repeat (2) cyc(1'b0, 1'b1);
      repeat (20) cyc(1'b0, 1'b0);
      // R8: mid-stream reset then restart from bit 0
      repeat (2) cyc(1'b1, 1'b0);
      repeat (12) cyc(1'b0, 1'b0);
      // R2: chip disabled while reset also active
      cyc(1'b1, 1'b1);
      repeat (4) cyc(1'b0, 1'b0);
      // Random interleavings, with long runs so the end is reached
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 199);
         cyc(r < 3, (r >= 3 && r < 6));
      end
      repeat (DEPTH + 3) cyc(1'b0, 1'b0);
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 20);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule